// File: doc/BRIEF.md
# Link Packet Transmitter with Replay

This block sits between an upper protocol layer and a byte-wide downstream path. The upper layer hands it packets as a byte stream with valid, last and ready. Each packet is written into a local replay store. The block then sends a framed copy downstream: two header bytes that carry a 12-bit sequence number, the payload, and a 32-bit check value. Every packet that has been sent stays in the store until the far end confirms it.

Confirmations come in on a sideband input. Each one is an ACK or a NAK with a sequence number. An ACK frees the named packet and all older ones. A NAK makes the block send again the named packet and every later stored packet, in their original order and with their original numbers. The upper layer is stalled while the store is full and while a replay is pending or running.

Top module: `lnk_replay_tx`

## Requirements
- R1: Each frame starts with header byte {4'b0000, seq[11:8]}, then header byte seq[7:0], then the payload bytes in the order they were accepted.
- R2: After reset the first new packet gets sequence number 0. Each later new packet gets the previous number plus one, modulo 4096, so 4095 is followed by 0.
- R3: The four bytes after the payload are a CRC-32. The polynomial is 0x04C11DB7, fed most significant bit first, with the register preset to all ones. It covers both header bytes and the payload. The register value is inverted and sent most significant byte first.
- R4: outLast is high on the final check byte only, so a frame with an n-byte payload is exactly n+6 bytes long.
- R5: While outValid is high and outReady is low, outValid, outData and outLast hold their values.
- R6: The store holds up to 4 unacknowledged packets of 1 to 64 payload bytes each. inReady is low whenever 4 packets are stored.
- R7: An ACK with number N frees packet N and every older stored packet, and inReady returns high once space exists.
- R8: A NAK with number N makes the block send again packet N and every later stored packet, in ascending sequence order, with unchanged numbers and bytes.
- R9: A NAK that arrives during a frame does not cut that frame short. The frame completes, and the replay starts after it.
- R10: An ACK or NAK whose number is not a stored packet that has already been sent once is ignored. It frees nothing and starts no replay.
- R11: inReady is low from the cycle after a NAK is accepted until every replayed packet has been sent.
- R12: During reset and right after it, outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Upstream payload byte |
| inValid | input | 1 | Upstream byte present |
| inLast | input | 1 | Upstream byte ends its packet |
| inReady | output | 1 | Block accepts an upstream byte this cycle |
| outData | output | 8 | Downstream frame byte |
| outValid | output | 1 | Downstream byte present |
| outLast | output | 1 | Downstream byte ends its frame |
| outReady | input | 1 | Downstream takes the byte this cycle |
| ackValid | input | 1 | Confirmation present |
| ackIsNak | input | 1 | 1 = NAK, 0 = ACK |
| ackSeq | input | 12 | Sequence number of the confirmation |

## Verification
The bench uses the default parameters: 12-bit numbers, 4 slots and 64-byte payloads. With only four slots, the store fills after four packets, which puts backpressure and full-store NAKs within reach of a few directed steps. With short payloads, more than four thousand packets run in well under the cycle limit, so the sequence counter wraps from 4095 to 0 with random downstream stalls. The full 64-byte payload is also the window in which a NAK lands during a frame.

// File: rtl/lnk_replay_pkg.sv
package lnk_replay_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic wrByte;    // store the accepted upstream byte
    logic wrClose;   // record the length of the slot being filled
    logic crcClear;  // preset the check register for a new frame
    logic crcStep;   // fold the current header/payload byte into it
  } dpStrobe_t;

  typedef enum logic [0:0] {TX_IDLE, TX_SEND} txState_t;

  // One byte of the check code, most significant bit first
  function automatic logic [31:0] crcNext(input logic [31:0] cur, input logic [7:0] b);
    logic [31:0] c;
    logic        fb;
    c = cur;
    for (int i = 7; i >= 0; i--) begin
      fb = c[31] ^ b[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/lnk_replay_dp.sv
module lnk_replay_dp
  import lnk_replay_pkg::*;
#(
  parameter int SEQ_W     = 12,
  parameter int SLOTS     = 4,
  parameter int MAX_BYTES = 64,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int POS_W    = $clog2(MAX_BYTES),
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int TXP_W    = $clog2(MAX_BYTES + 6)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [7:0]        inData,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [POS_W-1:0]  wrPos,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic [TXP_W-1:0]  txPos,
  input  logic [SEQ_W-1:0]  txSeq,
  output logic [LEN_W-1:0]  rdLen,
  output logic [7:0]        txByte
);

  localparam int DEPTH = SLOTS * MAX_BYTES;

  logic [7:0]       storeMem [DEPTH];
  logic [LEN_W-1:0] lenQ [SLOTS];
  logic [31:0]      crcQ;
  logic [31:0]      crcOut;
  logic [15:0]      hdrWord;
  logic [TXP_W-1:0] payEnd;
  logic [TXP_W-1:0] payIdx;
  logic [TXP_W-1:0] crcIdx;

  // Payload store, one region of MAX_BYTES per slot
  always_ff @(posedge clk) begin
    if (stb.wrByte) storeMem[{wrSlot, wrPos}] <= inData;
  end

  // Per-slot payload length, captured when the packet closes
  for (genvar g = 0; g < SLOTS; g++) begin : g_len
    always_ff @(posedge clk) begin
      if (!rstN) lenQ[g] <= '0;
      else if (stb.wrClose && wrSlot == SLOT_W'(g))
        lenQ[g] <= LEN_W'(wrPos) + LEN_W'(1);
    end
  end

  assign rdLen = lenQ[rdSlot];

  // Frame byte selection
  assign hdrWord = 16'(txSeq);
  assign payEnd  = TXP_W'(rdLen) + TXP_W'(2);
  assign payIdx  = txPos - TXP_W'(2);
  assign crcIdx  = txPos - payEnd;
  assign crcOut  = ~crcQ;

  always_comb begin
    if (txPos == '0)            txByte = hdrWord[15:8];
    else if (txPos == TXP_W'(1)) txByte = hdrWord[7:0];
    else if (txPos < payEnd)    txByte = storeMem[{rdSlot, payIdx[POS_W-1:0]}];
    else begin
      case (crcIdx[1:0])
        2'd0:    txByte = crcOut[31:24];
        2'd1:    txByte = crcOut[23:16];
        2'd2:    txByte = crcOut[15:8];
        default: txByte = crcOut[7:0];
      endcase
    end
  end

  // Running check value over header and payload
  always_ff @(posedge clk) begin
    if (!rstN)             crcQ <= '1;
    else if (stb.crcClear) crcQ <= '1;
    else if (stb.crcStep)  crcQ <= crcNext(crcQ, txByte);
  end

  // R3: the register is preset at the first header byte of every frame
  a_r3_preset_at_start: assert property (@(posedge clk) disable iff (!rstN)
    stb.crcClear |=> (crcQ == 32'hFFFF_FFFF));

endmodule

// File: rtl/lnk_replay_ctl.sv
module lnk_replay_ctl
  import lnk_replay_pkg::*;
#(
  parameter int SEQ_W     = 12,
  parameter int SLOTS     = 4,
  parameter int MAX_BYTES = 64,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int POS_W    = $clog2(MAX_BYTES),
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int TXP_W    = $clog2(MAX_BYTES + 6)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              outValid,
  output logic              outLast,
  input  logic              outReady,
  input  logic              ackValid,
  input  logic              ackIsNak,
  input  logic [SEQ_W-1:0]  ackSeq,
  input  logic [LEN_W-1:0]  rdLen,
  output dpStrobe_t         stb,
  output logic [SLOT_W-1:0] wrSlot,
  output logic [POS_W-1:0]  wrPos,
  output logic [SLOT_W-1:0] rdSlot,
  output logic [TXP_W-1:0]  txPos,
  output logic [SEQ_W-1:0]  txSeq
);

  txState_t         state;
  logic [SEQ_W-1:0] nextSeq;    // number for the packet being written
  logic [SEQ_W-1:0] ackBase;    // oldest unconfirmed packet
  logic [SEQ_W-1:0] firstNew;   // oldest packet never sent
  logic [SEQ_W-1:0] sendSeq;    // packet sent now or next
  logic [SEQ_W-1:0] replaySeq;
  logic             replayPend;
  logic             replayMode;
  logic [POS_W-1:0] wrPosQ;
  logic [TXP_W-1:0] txPosQ;

  logic [SEQ_W-1:0] storedCnt, sentCnt, sendOff, ackOff;
  logic             ackHit, inFire, pktClose, outFire, frameEnd;
  logic             applyReplay, fixBehind, endReplay, startPkt;

  assign storedCnt = nextSeq - ackBase;
  assign sentCnt   = firstNew - ackBase;
  assign sendOff   = sendSeq - ackBase;
  assign ackOff    = ackSeq - ackBase;
  assign ackHit    = ackValid && (ackOff < sentCnt);

  assign inReady  = (storedCnt < SEQ_W'(SLOTS)) && !replayPend && !replayMode;
  assign inFire   = inValid && inReady;
  assign pktClose = inFire && (inLast || wrPosQ == POS_W'(MAX_BYTES - 1));

  assign outValid = (state == TX_SEND);
  assign outLast  = outValid && (txPosQ == TXP_W'(rdLen) + TXP_W'(5));
  assign outFire  = outValid && outReady;
  assign frameEnd = outFire && outLast;

  // Idle-time decisions, in priority order
  assign applyReplay = (state == TX_IDLE) && replayPend;
  assign fixBehind   = (state == TX_IDLE) && !replayPend && (sendOff > storedCnt);
  assign endReplay   = (state == TX_IDLE) && !replayPend && !fixBehind &&
                       replayMode && (sendSeq == firstNew);
  assign startPkt    = (state == TX_IDLE) && !replayPend && !fixBehind && !endReplay &&
                       (sendOff < storedCnt);

  assign stb.wrByte   = inFire;
  assign stb.wrClose  = pktClose;
  assign stb.crcClear = startPkt;
  assign stb.crcStep  = outFire && (txPosQ < TXP_W'(rdLen) + TXP_W'(2));

  assign wrSlot = nextSeq[SLOT_W-1:0];
  assign wrPos  = wrPosQ;
  assign rdSlot = sendSeq[SLOT_W-1:0];
  assign txPos  = txPosQ;
  assign txSeq  = sendSeq;

  // Upstream write side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextSeq <= '0;
      wrPosQ  <= '0;
    end else begin
      if (pktClose) begin
        nextSeq <= nextSeq + SEQ_W'(1);
        wrPosQ  <= '0;
      end else if (inFire) begin
        wrPosQ <= wrPosQ + POS_W'(1);
      end
    end
  end

  // Confirmation handling
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackBase    <= '0;
      replayPend <= 1'b0;
      replaySeq  <= '0;
    end else begin
      if (ackHit && !ackIsNak) ackBase <= ackSeq + SEQ_W'(1);
      if (ackHit && ackIsNak) begin
        replayPend <= 1'b1;
        replaySeq  <= ackSeq;
      end else if (applyReplay) begin
        replayPend <= 1'b0;
      end
    end
  end

  // Transmit side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= TX_IDLE;
      txPosQ     <= '0;
      sendSeq    <= '0;
      firstNew   <= '0;
      replayMode <= 1'b0;
    end else begin
      if (applyReplay) begin
        sendSeq    <= replaySeq;
        replayMode <= 1'b1;
      end else if (fixBehind) begin
        sendSeq <= ackBase;
      end else if (endReplay) begin
        replayMode <= 1'b0;
      end else if (startPkt) begin
        state  <= TX_SEND;
        txPosQ <= '0;
      end
      if (outFire) begin
        if (outLast) begin
          state   <= TX_IDLE;
          sendSeq <= sendSeq + SEQ_W'(1);
          if (sendSeq == firstNew) firstNew <= firstNew + SEQ_W'(1);
        end else begin
          txPosQ <= txPosQ + TXP_W'(1);
        end
      end
    end
  end

  // R6: never more packets held than slots
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    storedCnt <= SEQ_W'(SLOTS));

  // R5: a stalled byte keeps its position and packet
  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(txPosQ) && $stable(sendSeq)));

  // R9: the packet number does not change inside a frame
  a_r9_frame_completes: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !frameEnd) |=> (outValid && $stable(sendSeq)));

  // R11: no upstream byte enters during a replay
  a_r11_hold_new: assert property (@(posedge clk) disable iff (!rstN)
    (replayMode || replayPend) |-> !inFire);

  // R8: outside a replay the frame on the wire comes from a stored packet
  a_r8_send_stored: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !replayMode) |-> (sendOff < storedCnt));

endmodule

// File: rtl/lnk_replay_tx.sv
module lnk_replay_tx
  import lnk_replay_pkg::*;
#(
  parameter int SEQ_W     = 12,
  parameter int SLOTS     = 4,
  parameter int MAX_BYTES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  output logic [7:0]       outData,
  output logic             outValid,
  output logic             outLast,
  input  logic             outReady,
  input  logic             ackValid,
  input  logic             ackIsNak,
  input  logic [SEQ_W-1:0] ackSeq
);

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int POS_W  = $clog2(MAX_BYTES);
  localparam int LEN_W  = $clog2(MAX_BYTES + 1);
  localparam int TXP_W  = $clog2(MAX_BYTES + 6);

  dpStrobe_t         stb;
  logic [SLOT_W-1:0] wrSlot, rdSlot;
  logic [POS_W-1:0]  wrPos;
  logic [TXP_W-1:0]  txPos;
  logic [SEQ_W-1:0]  txSeq;
  logic [LEN_W-1:0]  rdLen;

  lnk_replay_ctl #(.SEQ_W(SEQ_W), .SLOTS(SLOTS), .MAX_BYTES(MAX_BYTES)) u_ctl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .outValid(outValid), .outLast(outLast), .outReady(outReady),
    .ackValid(ackValid), .ackIsNak(ackIsNak), .ackSeq(ackSeq),
    .rdLen(rdLen), .stb(stb),
    .wrSlot(wrSlot), .wrPos(wrPos), .rdSlot(rdSlot),
    .txPos(txPos), .txSeq(txSeq)
  );

  lnk_replay_dp #(.SEQ_W(SEQ_W), .SLOTS(SLOTS), .MAX_BYTES(MAX_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .wrSlot(wrSlot), .wrPos(wrPos), .rdSlot(rdSlot),
    .txPos(txPos), .txSeq(txSeq), .rdLen(rdLen), .txByte(outData)
  );

endmodule

// File: tb/test_lnk_replay_tx.sv
module test_lnk_replay_tx;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0, inLast = 1'b0, inReady;
  logic [7:0]  outData;
  logic        outValid, outLast;
  logic        outReady = 1'b0;
  logic        ackValid = 1'b0, ackIsNak = 1'b0;
  logic [11:0] ackSeq = '0;

  always #2.5 clk = ~clk;

  lnk_replay_tx i_lnk_replay_tx (
    .clk(clk), .rstN(rstN),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outLast(outLast), .outReady(outReady),
    .ackValid(ackValid), .ackIsNak(ackIsNak), .ackSeq(ackSeq)
  );

  int checks = 0, errors = 0;
  byte unsigned mData [16][64];
  int  mLen [16];
  int  expSeq = 0;
  int  rxLog [8192];
  int  rxN = 0;
  logic [7:0] frmBuf [128];
  int  frmCnt = 0;
  bit  rdyRandom = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crcUpd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {b, 24'h0};
    for (int i = 0; i < 8; i++) r = r[31] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  task automatic checkFrame();
    int s, k, n;
    bit ok;
    longint bAct, bExp;
    logic [31:0] c, got;
    s = {frmBuf[0][3:0], frmBuf[1]};
    k = s % 16;
    n = mLen[k];
    check(frmCnt == n + 6, "R4", "frame length", frmCnt, n + 6);
    ok = (frmBuf[0][7:4] == 4'h0);
    bAct = frmBuf[0]; bExp = {4'h0, frmBuf[0][3:0]};
    for (int i = 0; i < n; i++) begin
      if (ok && frmBuf[i+2] != mData[k][i]) begin
        ok = 1'b0; bAct = frmBuf[i+2]; bExp = mData[k][i];
      end
    end
    check(ok, "R1", $sformatf("header/payload of seq %0d", s), bAct, bExp);
    c = '1;
    for (int i = 0; i < n + 2; i++) c = crcUpd(c, frmBuf[i]);
    c = ~c;
    got = {frmBuf[n+2], frmBuf[n+3], frmBuf[n+4], frmBuf[n+5]};
    check(got == c, "R3", $sformatf("check value of seq %0d", s), got, c);
    rxLog[rxN % 8192] = s;
    rxN++;
  endtask

  // Downstream ready, changed just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      outReady = rdyRandom ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  // Frame monitor, samples at the falling edge
  initial begin : mon
    bit pStall;
    logic [7:0] pData;
    logic pLast;
    pStall = 1'b0; pData = '0; pLast = 1'b0;
    forever begin
      @(negedge clk);
      if (pStall)
        check(outValid === 1'b1 && outData === pData && outLast === pLast,
              "R5", "stalled byte held", outData, pData);
      pStall = outValid && !outReady;
      pData  = outData;
      pLast  = outLast;
      if (outValid && outReady) begin
        if (frmCnt < 128) frmBuf[frmCnt] = outData;
        frmCnt++;
        if (outLast) begin
          checkFrame();
          frmCnt = 0;
        end
      end
    end
  end

  task automatic sendPkt(input int len);
    int k;
    k = expSeq % 16;
    mLen[k] = len;
    for (int i = 0; i < len; i++) mData[k][i] = 8'($urandom);
    expSeq = (expSeq + 1) % 4096;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = mData[k][i]; inLast = (i == len - 1);
      while (!inReady) @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic sendAck(input bit nak, input int s);
    @(negedge clk);
    ackValid = 1'b1; ackIsNak = nak; ackSeq = 12'(s);
    @(negedge clk);
    ackValid = 1'b0; ackIsNak = 1'b0;
  endtask

  task automatic waitFrames(input int target);
    while (rxN < target) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int n0, base, breaks;
    bit sawWrap;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R12", "outValid in reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && inReady == 1'b1, "R12", "idle after reset",
          {outValid, inReady}, 2'b01);
    rdyRandom = 1'b1;

    // Three fresh packets: numbers 0,1,2 (R2), content checked per frame (R1 R3 R4)
    sendPkt(1); sendPkt(64); sendPkt(1 + $urandom % 20);
    waitFrames(3);
    for (int i = 0; i < 3; i++) check(rxLog[i] == i, "R2", "first numbers", rxLog[i], i);

    // Fourth packet fills the store (R6), ACK 1 frees two (R7)
    sendPkt(1 + $urandom % 30);
    waitFrames(4);
    repeat (2) @(negedge clk);
    check(inReady == 1'b0, "R6", "ready with 4 stored", inReady, 0);
    sendAck(1'b0, 1);
    repeat (2) @(negedge clk);
    check(inReady == 1'b1, "R7", "ready after ACK", inReady, 1);

    // Refill (stored 2..5), then confirmations for an unknown number (R10)
    sendPkt(5); sendPkt(1 + $urandom % 64);
    waitFrames(6);
    repeat (2) @(negedge clk);
    check(inReady == 1'b0, "R6", "ready with 4 stored again", inReady, 0);
    sendAck(1'b0, 9);
    repeat (3) @(negedge clk);
    check(inReady == 1'b0, "R10", "unknown ACK frees nothing", inReady, 0);
    n0 = rxN;
    sendAck(1'b1, 9);
    repeat (60) @(negedge clk);
    check(rxN == n0 && outValid == 1'b0, "R10", "unknown NAK starts nothing", rxN, n0);

    // NAK 3 replays 3,4,5 in order (R8)
    sendAck(1'b1, 3);
    check(inReady == 1'b0, "R11", "ready during replay", inReady, 0);
    waitFrames(n0 + 3);
    for (int i = 0; i < 3; i++)
      check(rxLog[n0 + i] == 3 + i, "R8", "replay order", rxLog[n0 + i], 3 + i);
    sendAck(1'b0, 2);
    repeat (4) @(negedge clk);
    check(inReady == 1'b1, "R7", "ready after ACK past replay", inReady, 1);
    sendAck(1'b0, 5);

    // NAK during a long frame: frame 7 completes, then 6 and 7 again (R9)
    n0 = rxN;
    sendPkt(3);
    waitFrames(n0 + 1);
    sendPkt(64);
    while (!(outValid && frmCnt >= 8)) @(negedge clk);
    sendAck(1'b1, 6);
    check(inReady == 1'b0, "R11", "ready after NAK mid frame", inReady, 0);
    waitFrames(n0 + 4);
    check(rxLog[n0 + 1] == 7, "R9", "interrupted frame sent whole first", rxLog[n0 + 1], 7);
    check(rxLog[n0 + 2] == 6 && rxLog[n0 + 3] == 7, "R8", "replay after frame",
          {rxLog[n0 + 2][11:0], rxLog[n0 + 3][11:0]}, {12'd6, 12'd7});
    repeat (6) @(negedge clk);
    check(inReady == 1'b1, "R11", "ready after replay done", inReady, 1);
    sendAck(1'b0, 7);

    // Random stream with running ACKs through the 4095 -> 0 wrap (R2)
    base = rxN;
    fork
      begin
        for (int p = 0; p < 4092; p++) sendPkt(1 + $urandom % 3);
      end
      begin
        int acked;
        acked = base;
        while (acked < base + 4092) begin
          @(negedge clk);
          if (rxN > acked) begin
            acked = rxN;
            sendAck(1'b0, rxLog[(acked - 1) % 8192]);
          end
        end
      end
    join
    breaks = 0;
    sawWrap = 1'b0;
    for (int i = base + 1; i < rxN; i++) begin
      if (rxLog[i % 8192] != (rxLog[(i - 1) % 8192] + 1) % 4096) breaks++;
      if (rxLog[i % 8192] == 0 && rxLog[(i - 1) % 8192] == 4095) sawWrap = 1'b1;
    end
    check(breaks == 0, "R2", "consecutive numbers in stream", breaks, 0);
    check(sawWrap, "R2", "wrap from 4095 to 0", sawWrap, 1);
    repeat (6) @(negedge clk);
    check(inReady == 1'b1 && outValid == 1'b0, "R7", "all confirmed at end",
          {inReady, outValid}, 2'b10);
    finishRun();
  end

endmodule